// File: doc/BRIEF.md
# Halfword-Swapping DMA Address Path

This block sits between a peripheral with a 16-bit data bus and a byte-oriented memory port. It turns each peripheral transfer request into one or more memory requests and moves the data as a byte stream in either direction. A request carries an offset, a byte length, a direction (write to memory or read from memory) and a flag that disables lane swapping. The memory address is built by OR-ing the offset into a programmable base register, so the base supplies the upper address bits.

When swapping is enabled, the block trims the request to whole halfwords by clearing bit 0 of both the address and the length. It then exchanges the two bytes of every halfword on their way through, which converts between the peripheral's lane order and memory order. In the same mode, writes to memory go out as a series of bursts of bounded size, and each burst starts where the previous one ended. With swapping disabled, address, length and byte order pass through untouched as a single memory request. Only one request is handled at a time. The block completes a request with a one-cycle `done` pulse, and a request that trims to zero length completes without touching memory.

Top module: `hsdma_path`

## Requirements
- R1: The memory address of a request is `req_offset | base` (bitwise OR, not a sum), using the base value held when the request is accepted. A base write after acceptance does not change the bursts of that request.
- R2: With `req_noswap`=1, a single memory request carries the unmodified address and length, for any length and for either direction. Bytes reach the sink in the order they leave the source.
- R3: With `req_noswap`=0, bit 0 of `mem_addr` and bit 0 of `mem_len` are 0, and the transfer moves exactly the trimmed number of bytes.
- R4: On swapped writes, the source bytes at positions 2k and 2k+1 appear at `wdst_data` in the order 2k+1, 2k.
- R5: On swapped reads, the memory bytes at positions 2k and 2k+1 appear at `rdst_data` in the order 2k+1, 2k, and the whole trimmed length goes out as one memory request.
- R6: Swapped writes go out as bursts of at most `BURST_MAX` (64) bytes. Each burst's address equals the previous burst's address plus the previous burst's length.
- R7: The last burst of a swapped write carries the remaining length, which is below `BURST_MAX` when the total is not a multiple of it. A total of exactly `BURST_MAX` gives one burst.
- R8: A request whose trimmed length is 0 raises `done` in the cycle after acceptance, and no memory request is issued.
- R9: `req_ready` is low from the cycle after a non-empty request is accepted until the cycle in which `done` is high, when it is high again. A request offered while busy is not taken.
- R10: `done` goes high for one cycle in the cycle after the last byte is taken by the sink. By then every expected byte has been delivered.
- R11: Once `mem_valid` is raised, it stays high, and `mem_addr` and `mem_len` stay stable, until `mem_ready` is seen.
- R12: After reset, `req_ready`=1 and `mem_valid`, `done`, `wdst_valid`, `rdst_valid`, `wsrc_ready` and `rsrc_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the base register |
| base_wdata | input | ADDR_W | New base value |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_offset | input | ADDR_W | Request offset, OR-ed into base |
| req_len | input | LEN_W | Request byte length |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_noswap | input | 1 | 1: no trimming, swapping or splitting |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request taken |
| mem_addr | output | ADDR_W | Memory burst address |
| mem_len | output | LEN_W | Memory burst length in bytes |
| mem_write | output | 1 | Memory request direction |
| wsrc_valid | input | 1 | Peripheral write byte valid |
| wsrc_ready | output | 1 | Peripheral write byte taken |
| wsrc_data | input | 8 | Peripheral write byte |
| wdst_valid | output | 1 | Byte to memory valid |
| wdst_ready | input | 1 | Byte to memory taken |
| wdst_data | output | 8 | Byte to memory |
| rsrc_valid | input | 1 | Byte from memory valid |
| rsrc_ready | output | 1 | Byte from memory taken |
| rsrc_data | input | 8 | Byte from memory |
| rdst_valid | output | 1 | Byte to peripheral valid |
| rdst_ready | input | 1 | Byte to peripheral taken |
| rdst_data | output | 8 | Byte to peripheral |

## Verification
A corrupted remaining-length or address register shows up on the memory port at the very next burst, as a wrong `mem_addr` or `mem_len`. It can also show up as a missing or extra burst before `done`. A wrong fill count in the lane-swap stage shows within one halfword: the bytes of that pair arrive unswapped or duplicated, and every later byte of the transfer shifts out of position. A wrong segment counter makes `done` come early or never, or leaves source bytes unconsumed. The scoreboard catches all of these on the first mismatched item rather than at the end of the transfer.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_ISSUE = 2'd1,
      HS_XFER  = 2'd2
   } hs_state_e;

endpackage

// File: rtl/hsdma_addr_former.sv
module hsdma_addr_former #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LANE_BYTES = 2,
   parameter int BURST_MAX  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_off,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              load_align,
   input  logic              load_split,
   input  logic              advance,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  seg_len,
   output logic              is_last,
   output logic [LEN_W-1:0]  load_len_eff
);

   localparam int BM_LOG  = $clog2(BURST_MAX);
   localparam bit BM_POW2 = ((1 << BM_LOG) == BURST_MAX);
   localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'(LANE_BYTES - 1);
   localparam logic [LEN_W-1:0]  LEN_MASK  = ~LEN_W'(LANE_BYTES - 1);
   localparam logic [LEN_W-1:0]  BURST_LEN = LEN_W'(BURST_MAX);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic              split_q;
   logic [ADDR_W-1:0] load_addr_c;
   logic              remain_ge_burst;

   always_comb begin
      load_addr_c  = load_off | base_q;
      load_len_eff = load_len;
      if (load_align) begin
         load_addr_c  = load_addr_c & ADDR_MASK;
         load_len_eff = load_len & LEN_MASK;
      end
   end

   generate
      if (BM_POW2) begin : g_cap_pow2
         assign remain_ge_burst = |remain_q[LEN_W-1:BM_LOG];
      end else begin : g_cap_cmp
         assign remain_ge_burst = (remain_q >= BURST_LEN);
      end
   endgenerate

   assign seg_len  = (split_q && remain_ge_burst) ? BURST_LEN : remain_q;
   assign is_last  = (remain_q == seg_len);
   assign cur_addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_we) begin
         base_q <= base_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         remain_q <= '0;
         split_q  <= 1'b0;
      end else if (load) begin
         addr_q   <= load_addr_c;
         remain_q <= load_len_eff;
         split_q  <= load_split;
      end else if (advance) begin
         addr_q   <= addr_q + ADDR_W'(seg_len);
         remain_q <= remain_q - seg_len;
      end
   end

   // R7: a non-final advance always leaves bytes to move
   assert_remain_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !is_last) |=> (remain_q != '0));

endmodule

// File: rtl/hsdma_lane_swap.sv
module hsdma_lane_swap #(
   parameter int LANE_BYTES = 2,
   parameter int BYTE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_en,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data
);

   localparam int CNT_W = $clog2(LANE_BYTES + 1);
   localparam int IDX_W = $clog2(LANE_BYTES);

   logic [BYTE_W-1:0] lane_q [LANE_BYTES];
   logic [CNT_W-1:0]  cnt_q;
   logic              drain_q;
   logic [CNT_W-1:0]  need_c;
   logic [IDX_W-1:0]  rd_idx;
   logic              in_fire;
   logic              out_fire;

   assign need_c    = swap_en ? CNT_W'(LANE_BYTES) : CNT_W'(1);
   assign in_ready  = !drain_q;
   assign out_valid = drain_q;
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;
   assign rd_idx    = swap_en ? IDX_W'(cnt_q - CNT_W'(1)) : '0;
   assign out_data  = lane_q[rd_idx];

   always_ff @(posedge clk) begin
      if (in_fire) begin
         lane_q[IDX_W'(cnt_q)] <= in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         drain_q <= 1'b0;
      end else if (in_fire) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q + CNT_W'(1) == need_c) begin
            drain_q <= 1'b1;
         end
      end else if (out_fire) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) begin
            drain_q <= 1'b0;
         end
      end
   end

   // R4: the fill count never exceeds one lane
   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LANE_BYTES));

   // R4: the rest of a swapped lane follows without a gap
   assert_lane_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && swap_en && cnt_q > CNT_W'(1)) |=> out_valid);

endmodule

// File: rtl/hsdma_path.sv
module hsdma_path #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LANE_BYTES = 2,
   parameter int BURST_MAX  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   input  logic              req_noswap,
   output logic              done,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   output logic              mem_write,
   input  logic              wsrc_valid,
   output logic              wsrc_ready,
   input  logic [7:0]        wsrc_data,
   output logic              wdst_valid,
   input  logic              wdst_ready,
   output logic [7:0]        wdst_data,
   input  logic              rsrc_valid,
   output logic              rsrc_ready,
   input  logic [7:0]        rsrc_data,
   output logic              rdst_valid,
   input  logic              rdst_ready,
   output logic [7:0]        rdst_data
);

   import hsdma_pkg::*;

   generate
      if (LANE_BYTES < 2 || (LANE_BYTES & (LANE_BYTES - 1)) != 0) begin : g_bad_lane
         $error("LANE_BYTES must be a power of two of at least 2");
      end
      if (BURST_MAX < LANE_BYTES || (BURST_MAX % LANE_BYTES) != 0) begin : g_bad_burst
         $error("BURST_MAX must be a whole number of lanes");
      end
      if (BURST_MAX >= (1 << (LEN_W - 1))) begin : g_bad_len
         $error("LEN_W too narrow for BURST_MAX");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   hs_state_e         state_q;
   logic              write_q;
   logic              swap_q;
   logic              done_q;
   logic [LEN_W-1:0]  in_left_q;
   logic [LEN_W-1:0]  out_left_q;

   logic              accept;
   logic              advance;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  seg_len;
   logic              is_last;
   logic [LEN_W-1:0]  eff_len;

   logic              xfer;
   logic              st_in_valid;
   logic              st_in_ready;
   logic [BYTE_W-1:0] st_in_data;
   logic              st_out_valid;
   logic              st_out_ready;
   logic [BYTE_W-1:0] st_out_data;
   logic              src_fire;
   logic              snk_fire;

   assign req_ready = (state_q == HS_IDLE);
   assign accept    = req_valid && req_ready;
   assign xfer      = (state_q == HS_XFER);
   assign done      = done_q;
   assign mem_valid = (state_q == HS_ISSUE);
   assign mem_addr  = cur_addr;
   assign mem_len   = seg_len;
   assign mem_write = write_q;

   hsdma_addr_former #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .LANE_BYTES (LANE_BYTES),
      .BURST_MAX  (BURST_MAX)
   ) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_we      (base_we),
      .base_wdata   (base_wdata),
      .load         (accept),
      .load_off     (req_offset),
      .load_len     (req_len),
      .load_align   (!req_noswap),
      .load_split   (req_write && !req_noswap),
      .advance      (advance),
      .cur_addr     (cur_addr),
      .seg_len      (seg_len),
      .is_last      (is_last),
      .load_len_eff (eff_len)
   );

   // source and sink steering for the shared lane-swap stage
   always_comb begin
      st_in_valid  = 1'b0;
      st_in_data   = write_q ? wsrc_data : rsrc_data;
      wsrc_ready   = 1'b0;
      rsrc_ready   = 1'b0;
      if (xfer && in_left_q != '0) begin
         st_in_valid = write_q ? wsrc_valid : rsrc_valid;
         wsrc_ready  = write_q && st_in_ready;
         rsrc_ready  = !write_q && st_in_ready;
      end
      wdst_valid   = xfer && write_q && st_out_valid;
      rdst_valid   = xfer && !write_q && st_out_valid;
      st_out_ready = xfer && (write_q ? wdst_ready : rdst_ready);
   end

   assign wdst_data = st_out_data;
   assign rdst_data = st_out_data;
   assign src_fire  = st_in_valid && st_in_ready;
   assign snk_fire  = st_out_valid && st_out_ready;
   assign advance   = xfer && snk_fire && (out_left_q == LEN_W'(1));

   hsdma_lane_swap #(
      .LANE_BYTES (LANE_BYTES),
      .BYTE_W     (BYTE_W)
   ) u_swap (
      .clk       (clk),
      .rst_n     (rst_n),
      .swap_en   (swap_q),
      .in_valid  (st_in_valid),
      .in_ready  (st_in_ready),
      .in_data   (st_in_data),
      .out_valid (st_out_valid),
      .out_ready (st_out_ready),
      .out_data  (st_out_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= HS_IDLE;
         write_q    <= 1'b0;
         swap_q     <= 1'b0;
         done_q     <= 1'b0;
         in_left_q  <= '0;
         out_left_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            HS_IDLE: begin
               if (accept) begin
                  write_q <= req_write;
                  swap_q  <= !req_noswap;
                  if (eff_len == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= HS_ISSUE;
                  end
               end
            end
            HS_ISSUE: begin
               if (mem_ready) begin
                  in_left_q  <= seg_len;
                  out_left_q <= seg_len;
                  state_q    <= HS_XFER;
               end
            end
            HS_XFER: begin
               if (src_fire) begin
                  in_left_q <= in_left_q - LEN_W'(1);
               end
               if (snk_fire) begin
                  out_left_q <= out_left_q - LEN_W'(1);
                  if (out_left_q == LEN_W'(1)) begin
                     if (is_last) begin
                        state_q <= HS_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= HS_ISSUE;
                     end
                  end
               end
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   // R3: swapped requests reach memory lane-aligned
   assert_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && swap_q) |-> (mem_addr[0] == 1'b0 && mem_len[0] == 1'b0));

   // R6: swapped write bursts are bounded and never empty
   assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && swap_q) |-> (mem_len <= LEN_W'(BURST_MAX) && mem_len != '0));

   // R11: request held until taken
   assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

   // R9: no new request accepted while memory traffic is pending
   assert_one_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || wdst_valid || rdst_valid) |-> !req_ready);

   // R10: done only follows a finished transfer or an empty request
   assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

// File: tb/test_hsdma_path.sv
module test_hsdma_path;

   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              base_we = 1'b0;
   logic [ADDR_W-1:0] base_wdata = '0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_offset = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic              req_write = 1'b0;
   logic              req_noswap = 1'b0;
   logic              done;
   logic              mem_valid;
   logic              mem_ready = 1'b0;
   logic [ADDR_W-1:0] mem_addr;
   logic [LEN_W-1:0]  mem_len;
   logic              mem_write;
   logic              wsrc_valid = 1'b0;
   logic              wsrc_ready;
   logic [7:0]        wsrc_data = '0;
   logic              wdst_valid;
   logic              wdst_ready = 1'b0;
   logic [7:0]        wdst_data;
   logic              rsrc_valid = 1'b0;
   logic              rsrc_ready;
   logic [7:0]        rsrc_data = '0;
   logic              rdst_valid;
   logic              rdst_ready = 1'b0;
   logic [7:0]        rdst_data;

   hsdma_path i_hsdma_path (.*);

   always #5ns clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int mem_fires = 0;
   bit finished = 1'b0;
   logic [ADDR_W-1:0] model_base = '0;

   logic [ADDR_W-1:0] exp_addr_q[$];
   logic [LEN_W-1:0]  exp_len_q[$];
   logic              exp_wr_q[$];
   string             exp_rtag[$];
   logic [7:0]        exp_w_q[$];
   string             exp_w_tag[$];
   logic [7:0]        exp_r_q[$];
   string             exp_r_tag[$];
   logic [7:0]        wsrc_feed[$];
   logic [7:0]        rsrc_feed[$];

   function automatic logic [7:0] mem_byte(logic [ADDR_W-1:0] a);
      return (a[7:0] ^ 8'hA5) + {6'd0, a[9:8]};
   endfunction

   function automatic logic [7:0] src_byte(int seed, int i);
      return 8'(seed + i * 7);
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // stimulus on the posedge + 1 ns
   always @(posedge clk) begin
      #1;
      cyc++;
      wsrc_valid = (wsrc_feed.size() > 0);
      wsrc_data  = (wsrc_feed.size() > 0) ? wsrc_feed[0] : 8'h00;
      rsrc_valid = (rsrc_feed.size() > 0);
      rsrc_data  = (rsrc_feed.size() > 0) ? rsrc_feed[0] : 8'h00;
      mem_ready  = (cyc % 3) != 1;
      wdst_ready = (cyc % 4) != 2;
      rdst_ready = (cyc % 5) != 3;
   end

   // scoreboard monitor on the negedge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_valid && mem_ready) begin
            mem_fires++;
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected memory request", mem_addr, 0);
            end else begin
               string t;
               t = exp_rtag.pop_front();
               chk(mem_addr == exp_addr_q[0], t, "mem_addr", mem_addr, exp_addr_q[0]);
               chk(mem_len == exp_len_q[0], t, "mem_len", mem_len, exp_len_q[0]);
               chk(mem_write == exp_wr_q[0], t, "mem_write", mem_write, exp_wr_q[0]);
               void'(exp_addr_q.pop_front());
               void'(exp_len_q.pop_front());
               void'(exp_wr_q.pop_front());
            end
            if (!mem_write) begin
               for (int i = 0; i < int'(mem_len); i++) begin
                  rsrc_feed.push_back(mem_byte(mem_addr + ADDR_W'(i)));
               end
            end
         end
         if (wsrc_valid && wsrc_ready) void'(wsrc_feed.pop_front());
         if (rsrc_valid && rsrc_ready) void'(rsrc_feed.pop_front());
         if (wdst_valid && wdst_ready) begin
            if (exp_w_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected byte to memory", wdst_data, 0);
            end else begin
               chk(wdst_data == exp_w_q[0], exp_w_tag[0], "wdst_data", wdst_data, exp_w_q[0]);
               void'(exp_w_q.pop_front());
               void'(exp_w_tag.pop_front());
            end
         end
         if (rdst_valid && rdst_ready) begin
            if (exp_r_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected byte to peripheral", rdst_data, 0);
            end else begin
               chk(rdst_data == exp_r_q[0], exp_r_tag[0], "rdst_data", rdst_data, exp_r_q[0]);
               void'(exp_r_q.pop_front());
               void'(exp_r_tag.pop_front());
            end
         end
      end
   end

   task automatic set_base(logic [ADDR_W-1:0] b);
      @(posedge clk); #1;
      base_we    = 1'b1;
      base_wdata = b;
      @(posedge clk); #1;
      base_we    = 1'b0;
      model_base = b;
   endtask

   // driver: pushes expectations, offers the request, waits for completion
   task automatic do_req(logic [ADDR_W-1:0] off, int len, bit wr, bit noswap,
                         string rtag, bit new_base, logic [ADDR_W-1:0] nb);
      logic [ADDR_W-1:0] a;
      int alen;
      int seed;
      int fires0;
      int wait_cyc;
      a    = off | model_base;
      alen = len;
      seed = len * 13 + 5;
      if (!noswap) begin
         a[0] = 1'b0;
         alen = alen & ~1;
      end
      if (alen > 0) begin
         if (wr && !noswap) begin
            int rem;
            logic [ADDR_W-1:0] ba;
            rem = alen;
            ba  = a;
            while (rem > 0) begin
               int seg;
               seg = (rem > 64) ? 64 : rem;
               exp_addr_q.push_back(ba);
               exp_len_q.push_back(LEN_W'(seg));
               exp_wr_q.push_back(1'b1);
               exp_rtag.push_back(rtag != "" ? rtag : (rem <= 64 ? "R7" : "R6"));
               ba  = ba + ADDR_W'(seg);
               rem = rem - seg;
            end
         end else begin
            exp_addr_q.push_back(a);
            exp_len_q.push_back(LEN_W'(alen));
            exp_wr_q.push_back(wr);
            exp_rtag.push_back(rtag != "" ? rtag : (noswap ? "R2" : "R5"));
         end
         for (int i = 0; i < alen; i++) begin
            int idx;
            idx = noswap ? i : (i ^ 1);
            if (wr) begin
               wsrc_feed.push_back(src_byte(seed, i));
               exp_w_q.push_back(src_byte(seed, idx));
               exp_w_tag.push_back(noswap ? "R2" : "R4");
            end else begin
               exp_r_q.push_back(mem_byte(a + ADDR_W'(idx)));
               exp_r_tag.push_back(noswap ? "R2" : "R5");
            end
         end
      end
      fires0 = mem_fires;
      @(posedge clk); #1;
      req_offset = off;
      req_len    = LEN_W'(len);
      req_write  = wr;
      req_noswap = noswap;
      req_valid  = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      if (alen == 0) begin
         chk(done == 1'b1, "R8", "done after empty request", done, 1);
         repeat (6) @(negedge clk);
         chk(mem_fires == fires0, "R8", "memory requests for empty request", mem_fires, fires0);
         chk(req_ready == 1'b1, "R8", "ready after empty request", req_ready, 1);
         return;
      end
      chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
      if (new_base) begin
         set_base(nb);
      end
      wait_cyc = 0;
      while (!done && wait_cyc < 5000) begin
         @(negedge clk);
         wait_cyc++;
      end
      chk(done == 1'b1, "R10", "done seen", done, 1);
      chk(req_ready == 1'b1, "R9", "ready in done cycle", req_ready, 1);
      chk(exp_w_q.size() == 0 && exp_r_q.size() == 0, "R10", "bytes left at done",
          exp_w_q.size() + exp_r_q.size(), 0);
      chk(exp_addr_q.size() == 0, "R6", "bursts left at done", exp_addr_q.size(), 0);
      chk(wsrc_feed.size() == 0, "R3", "source bytes left", wsrc_feed.size(), 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
   endtask

   // busy refusal: a second request offered during a transfer is not taken
   task automatic busy_refusal();
      int fires0;
      exp_addr_q.push_back(ADDR_W'(32'h0000_0F40) | model_base);
      exp_len_q.push_back(LEN_W'(6));
      exp_wr_q.push_back(1'b0);
      exp_rtag.push_back("R9");
      for (int i = 0; i < 6; i++) begin
         exp_r_q.push_back(mem_byte((ADDR_W'(32'h0000_0F40) | model_base) + ADDR_W'(i)));
         exp_r_tag.push_back("R9");
      end
      @(posedge clk); #1;
      req_offset = 32'h0000_0F40; req_len = 6; req_write = 1'b0; req_noswap = 1'b1;
      req_valid  = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_offset = 32'h0000_0004; req_len = 2;
      fires0 = mem_fires;
      repeat (4) @(posedge clk);
      #1 req_valid = 1'b0;
      while (!done) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(mem_fires == fires0 + 1, "R9", "requests taken while busy", mem_fires, fires0 + 1);
      chk(exp_r_q.size() == 0, "R9", "bytes of first request", exp_r_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R12", "req_ready in reset", req_ready, 1);
      chk(mem_valid == 1'b0 && done == 1'b0, "R12", "mem_valid/done in reset",
          {mem_valid, done}, 0);
      chk(wdst_valid == 1'b0 && rdst_valid == 1'b0, "R12", "stream valids in reset",
          {wdst_valid, rdst_valid}, 0);
      chk(wsrc_ready == 1'b0 && rsrc_ready == 1'b0, "R12", "stream readies in reset",
          {wsrc_ready, rsrc_ready}, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      set_base(32'h8000_0000);
      do_req(32'h0000_0013, 7, 1'b1, 1'b1, "R2", 1'b0, '0);    // R2 odd no-swap write
      do_req(32'h0000_0200, 100, 1'b1, 1'b1, "R2", 1'b0, '0);  // R2 long write, not split
      do_req(32'h0000_0021, 9, 1'b1, 1'b0, "R3", 1'b0, '0);    // R3 R4 trimmed write
      set_base(32'h4000_0000);
      // R6 R7 three bursts; R1 base rewritten mid-flight
      do_req(32'h0000_0100, 130, 1'b1, 1'b0, "", 1'b1, 32'h0000_0F00);
      do_req(32'h0000_0130, 4, 1'b0, 1'b1, "R1", 1'b0, '0);    // R1 OR, not sum
      do_req(32'h0000_0007, 11, 1'b0, 1'b0, "R5", 1'b0, '0);   // R5 R3 trimmed read
      do_req(32'h0000_0040, 150, 1'b0, 1'b0, "R5", 1'b0, '0);  // R5 long read, one request
      do_req(32'h0000_0055, 5, 1'b0, 1'b1, "R2", 1'b0, '0);    // R2 odd no-swap read
      do_req(32'h0000_0031, 1, 1'b1, 1'b0, "R8", 1'b0, '0);    // R8 trims to zero
      do_req(32'h0000_0010, 0, 1'b0, 1'b1, "R8", 1'b0, '0);    // R8 zero length
      do_req(32'h0000_0080, 64, 1'b1, 1'b0, "R7", 1'b0, '0);   // R7 exactly one burst
      do_req(32'h0000_0003, 66, 1'b1, 1'b0, "", 1'b0, '0);     // R6 R7 short tail
      busy_refusal();                                          // R9
      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule